// File: doc/BRIEF.md
# Flash Busy-Poll Command Sequencer

This block is the command front end for a serial NOR flash on a single-lane SPI bus. A client hands it one request at a time: a read, a write or an erase, with a 24-bit address and, for writes, one data byte. Before any request reaches the flash, the sequencer opens a chip-select frame, sends the status-read opcode and collects the returned status byte. If the write-in-progress bit of that byte is set, it closes the frame and polls again. There is no retry limit, so the block stays busy for as long as the flash reports busy. Once the flash reports idle, the sequencer sends the request: a read directly, or a write or erase after a separate write-enable frame.

An erase or write is reported complete as soon as its command frame has been shifted out and chip select has risen. The flash then works on its own. Its busy time is absorbed by the poll at the start of the next request, not by the request that caused it.

A 32-bit status word mirrors the block's condition. It holds a ready flag and the status byte from the most recent poll. Software or a neighbouring block can read it, but only the fields defined below are stable. The other bits expose internal state and may be anything.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every accepted request starts with a status-poll frame: chip select low, opcode 0x05, then one returned byte, then chip select high. This happens before any other frame of that request.
- R2: While the polled byte has bit 0 (write in progress) set, the sequencer opens another poll frame. No write-enable or command frame is sent until a polled byte has bit 0 clear.
- R3: The poll has no timeout. A flash that stays busy for hundreds of polls still leads to a normal completion once it reports idle.
- R4: An erase is selected by req_op 2 or 3. It sends a one-byte 0x06 frame, then a frame of 0x20 followed by the 24-bit address, most significant byte first. done pulses once that frame has closed, without waiting for the flash to finish erasing.
- R5: A write (req_op 1) sends a one-byte 0x06 frame, then a frame of 0x02, the 24-bit address (most significant byte first) and the data byte.
- R6: A read (req_op 0) sends no write-enable frame. It sends one frame of 0x03, the 24-bit address, then one clocked-in byte. That byte appears on rd_data when done pulses and holds until the next read completes.
- R7: status_word[31:24] equals the byte returned by the most recent poll. It changes only when a poll completes, never while the block is idle.
- R8: status_word[3] is the ready flag. It is 1 exactly when req_ready is 1, which is only in the idle state. A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the cycle after done.
- R9: The SPI bus runs in mode 0 at half the clock rate, most significant bit first. spi_sck is low whenever chip select is high. Chip select is high for at least one clock between consecutive frames.
- R10: done is a single-cycle pulse, one per accepted request. It is raised in the cycle in which chip select has returned high after the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; the request is taken when req_valid is also 1 |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 erase |
| req_addr | input | 24 | Flash byte address |
| req_wdata | input | 8 | Data byte for a write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| status_word | output | 32 | [31:24] last polled flash status, [3] ready, other bits internal |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock (mode 0) |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

Back-pressure: the request side is valid/ready. req_valid may rise at any time and should stay high with stable fields until accepted. The result side has no back-pressure: done is a pulse and rd_data is held.

## Verification
The assertions assume three things about the inputs. req_valid, req_op, req_addr and req_wdata are not X after reset. spi_miso carries a defined level on the edges where sck rises inside a frame. The flash changes its busy state only between frames, so a single poll returns one consistent byte. The bench keeps within these assumptions. Its flash model drives spi_miso from its bit counter and updates busy only when chip select rises. Request fields are held stable until the edge on which req_ready is sampled high. Random polling depths, status patterns, addresses and opcodes are drawn only while the sequencer is idle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // request operation codes on req_op
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;

  // flash opcodes
  localparam logic [7:0] OPC_STATUS       = 8'h05;
  localparam logic [7:0] OPC_WEN          = 8'h06;
  localparam logic [7:0] OPC_PROGRAM      = 8'h02;
  localparam logic [7:0] OPC_SECTOR_ERASE = 8'h20;
  localparam logic [7:0] OPC_READ         = 8'h03;
  localparam logic [7:0] OPC_FILL         = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_POLL = 3'd1,
    ST_PGAP = 3'd2,
    ST_WREN = 3'd3,
    ST_WGAP = 3'd4,
    ST_CMD  = 3'd5,
    ST_DONE = 3'd6
  } seq_state_e;

  function automatic logic [7:0] opcode_for(input logic [1:0] op);
    case (op)
      OP_READ:  return OPC_READ;
      OP_WRITE: return OPC_PROGRAM;
      default:  return OPC_SECTOR_ERASE;
    endcase
  endfunction

endpackage

// File: rtl/flash_spi_shifter.sv
// Byte shifter for SPI mode 0 at clk/2. Each bit spends one clock with
// sck low and one with sck high; miso is sampled as sck rises.
module flash_spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sh_q;
  logic [W-1:0]     rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          sh_q    <= tx;
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          cnt_q   <= '0;
        end
      end else if (!phase_q) begin
        phase_q <= 1'b1;
        rx_q    <= {rx_q[W-2:0], miso};
      end else begin
        phase_q <= 1'b0;
        sh_q    <= {sh_q[W-2:0], 1'b0};
        if (cnt_q == CNT_W'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck  = busy_q & phase_q;
  assign mosi = sh_q[W-1];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

endmodule

// File: rtl/flash_status_word.sv
// Status word: [31:24] last polled flash byte, [3] ready, rest internal.
module flash_status_word #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              ready,
  input  logic [2:0]        state_code,
  input  logic              shift_busy,
  output logic [31:0]       word
);
  localparam int PAD_W = 32 - BYTE_W - 8;

  logic [BYTE_W-1:0] flash_stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flash_stat_q <= '0;
    else if (cap) flash_stat_q <= cap_byte;
  end

  assign word = {flash_stat_q, {PAD_W{1'b0}}, 1'b0, state_code,
                 ready, 1'b0, shift_busy, 1'b0};

endmodule

// File: rtl/flash_seq_ctrl.sv
// Sequencer: poll loop, write-enable frame, command frame, completion.
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              cs_n,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              poll_cap,
  output logic [2:0]        state_code
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 2);
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  seq_state_e        state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [IDX_W-1:0]  idx;
  logic              issued;
  logic              cs_n_q;
  logic [7:0]        rd_q;
  logic              wip_q;

  logic              rd_op;
  logic              wr_op;
  logic              frame_st;
  logic [IDX_W-1:0]  last_idx;
  logic [AB_W-1:0]   ab_sel;
  logic [7:0]        addr_byte [ADDR_BYTES];

  assign rd_op    = (op_q == OP_READ);
  assign wr_op    = (op_q == OP_WRITE);
  assign frame_st = (state == ST_POLL) || (state == ST_WREN) || (state == ST_CMD);
  assign last_idx = (rd_op || wr_op) ? IDX_W'(ADDR_BYTES + 1) : IDX_W'(ADDR_BYTES);
  assign ab_sel   = AB_W'(idx - 1'b1);

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign addr_byte[g] = addr_q[ADDR_W-1-8*g -: 8];
  end

  always_comb begin
    sh_tx = OPC_FILL;
    case (state)
      ST_POLL: sh_tx = (idx == '0) ? OPC_STATUS : OPC_FILL;
      ST_WREN: sh_tx = OPC_WEN;
      ST_CMD: begin
        if (idx == '0)                           sh_tx = opcode_for(op_q);
        else if (idx <= IDX_W'(ADDR_BYTES))      sh_tx = addr_byte[ab_sel];
        else if (wr_op)                          sh_tx = wdata_q;
        else                                     sh_tx = OPC_FILL;
      end
      default: sh_tx = OPC_FILL;
    endcase
  end

  assign sh_start = frame_st && !issued && !sh_busy;
  assign poll_cap = (state == ST_POLL) && sh_done && (idx == IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx     <= '0;
      issued  <= 1'b0;
      cs_n_q  <= 1'b1;
      rd_q    <= '0;
      wip_q   <= 1'b0;
    end else begin
      if (sh_start)     issued <= 1'b1;
      else if (sh_done) issued <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          idx     <= '0;
          cs_n_q  <= 1'b0;
          state   <= ST_POLL;
        end
        ST_POLL: if (sh_done) begin
          if (idx == IDX_W'(1)) begin
            wip_q  <= sh_rx[0];
            cs_n_q <= 1'b1;
            idx    <= '0;
            state  <= ST_PGAP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PGAP: begin
          cs_n_q <= 1'b0;
          if (wip_q)      state <= ST_POLL;
          else if (rd_op) state <= ST_CMD;
          else            state <= ST_WREN;
        end
        ST_WREN: if (sh_done) begin
          cs_n_q <= 1'b1;
          state  <= ST_WGAP;
        end
        ST_WGAP: begin
          cs_n_q <= 1'b0;
          state  <= ST_CMD;
        end
        ST_CMD: if (sh_done) begin
          if (idx == last_idx) begin
            cs_n_q <= 1'b1;
            idx    <= '0;
            if (rd_op) rd_q <= sh_rx;
            state  <= ST_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign done       = (state == ST_DONE);
  assign rd_data    = rd_q;
  assign cs_n       = cs_n_q;
  assign state_code = state;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n_q);
  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  cs_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> !sh_busy);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic [31:0]       status_word,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_busy;
  logic       sh_done;
  logic [7:0] sh_rx;
  logic       poll_cap;
  logic [2:0] state_code;

  flash_seq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .done      (done),
    .rd_data   (rd_data),
    .cs_n      (spi_cs_n),
    .sh_start  (sh_start),
    .sh_tx     (sh_tx),
    .sh_busy   (sh_busy),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx),
    .poll_cap  (poll_cap),
    .state_code(state_code)
  );

  flash_spi_shifter #(.W(8)) shift_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .busy  (sh_busy),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  flash_status_word #(.BYTE_W(8)) stat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (poll_cap),
    .cap_byte  (sh_rx),
    .ready     (req_ready),
    .state_code(state_code),
    .shift_busy(sh_busy),
    .word      (status_word)
  );

  // R2
  cmd_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && (state_code == ST_WREN || state_code == ST_CMD)) |-> !status_word[24]);
  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> $stable(status_word[31:24]));
  // R8
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == status_word[3]);
  // R9
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rd_data;
  logic [31:0] status_word;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .status_word(status_word), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model ----------------
  int          bitcnt = 0, nbytes = 0, nf = 0, busy_left = 0, post_busy = 0;
  logic [7:0]  sh_in = '0, cur_op = 8'hFF, cur_data = '0;
  logic [23:0] cur_addr = '0;
  logic [6:0]  stat_hi = 7'h21;
  logic [7:0]  log_op   [512];
  int          log_nb   [512];
  logic [23:0] log_addr [512];
  logic [7:0]  log_data [512];

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(negedge spi_cs_n) begin
    bitcnt = 0; nbytes = 0; cur_op = 8'hFF;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh_in = {sh_in[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      nbytes++;
      case (nbytes)
        1: cur_op = sh_in;
        2, 3, 4: cur_addr = {cur_addr[15:0], sh_in};
        5: cur_data = sh_in;
        default: ;
      endcase
    end
  end

  always @(posedge spi_cs_n) if (nbytes > 0) begin
    if (nf < 512) begin
      log_op[nf] = cur_op; log_nb[nf] = nbytes;
      log_addr[nf] = cur_addr; log_data[nf] = cur_data;
    end
    nf++;
    if (cur_op == 8'h05 && busy_left > 0) busy_left--;
    if ((cur_op == 8'h02 || cur_op == 8'h20) && nbytes >= 4) busy_left = post_busy;
    nbytes = 0;
  end

  always @* begin
    logic [7:0] sb;
    logic [7:0] mb;
    sb = {stat_hi, busy_left > 0};
    mb = mem_byte(cur_addr);
    spi_miso = 1'b0;
    if (!spi_cs_n) begin
      if (cur_op == 8'h05 && bitcnt >= 8 && bitcnt < 16) spi_miso = sb[15 - bitcnt];
      else if (cur_op == 8'h03 && bitcnt >= 32 && bitcnt < 40) spi_miso = mb[39 - bitcnt];
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_opcode(input logic [1:0] op);
    if (op == 2'd0) return 8'h03;
    if (op == 2'd1) return 8'h02;
    return 8'h20;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [23:0] addr, input logic [7:0] wd);
    int exp_polls, base, cyc, bad_polls, exp_nb;
    bit r;
    exp_polls = busy_left + 1;
    nf = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 1'b0;
    chk(status_word[3] == 1'b0 && !req_ready, "R8", "ready low after accept", status_word[3], 0);
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done, "R3", "request completes despite busy polls", done, 1);
    bad_polls = 0;
    for (int i = 0; i < exp_polls; i++)
      if (log_op[i] != 8'h05 || log_nb[i] != 2) bad_polls++;
    chk(bad_polls == 0, "R1", "poll frames lead every request", bad_polls, 0);
    base = exp_polls;
    if (op != 2'd0) begin
      chk(log_op[base] == 8'h06 && log_nb[base] == 1, (op == 2'd1) ? "R5" : "R4",
          "write-enable frame after polls", log_op[base], 8'h06);
      base++;
    end
    chk(nf == base + 1, "R2", "frame count (polls until idle, then command)", nf, base + 1);
    exp_nb = (op >= 2'd2) ? 4 : 5;
    chk(log_op[base] == exp_opcode(op), (op == 2'd0) ? "R6" : (op == 2'd1) ? "R5" : "R4",
        "command opcode", log_op[base], exp_opcode(op));
    chk(log_addr[base] == addr && log_nb[base] == exp_nb, "R9", "address msb first, frame length",
        log_addr[base], addr);
    if (op == 2'd1)
      chk(log_data[base] == wd, "R5", "program data byte", log_data[base], wd);
    if (op == 2'd0)
      chk(rd_data == mem_byte(addr), "R6", "read data", rd_data, mem_byte(addr));
    if (op >= 2'd2 && post_busy > 0)
      chk(busy_left == post_busy, "R4", "erase done while flash still busy", busy_left, post_busy);
    chk(status_word[31:24] == {stat_hi, 1'b0}, "R7", "mirrored status byte",
        status_word[31:24], {stat_hi, 1'b0});
    chk(spi_cs_n, "R10", "cs high at done", spi_cs_n, 1);
    @(negedge clk);
    chk(!done && req_ready && status_word[3], "R10", "done single pulse, ready back",
        {done, req_ready, status_word[3]}, 3'b011);
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && status_word[3] && !done && spi_cs_n && !spi_sck, "R8", "reset state",
        {req_ready, status_word[3], done, spi_cs_n, spi_sck}, 5'b11010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(status_word[31:24] == 8'h00, "R7", "status byte after reset", status_word[31:24], 0);

    // directed: idle read, busy write, erase with busy aftermath
    busy_left = 0; post_busy = 0;
    run_op(2'd0, 24'h12_34_56, 8'h00);
    busy_left = 2; stat_hi = 7'h15;
    run_op(2'd1, 24'hA0_00_FF, 8'h5A);
    post_busy = 3; stat_hi = 7'h4B;
    run_op(2'd2, 24'h00_10_00, 8'h00);

    // R7: flash status changes while idle, mirror must not move
    held = status_word[31:24];
    stat_hi = 7'h7F;
    repeat (30) @(negedge clk);
    chk(status_word[31:24] == held, "R7", "no background refresh", status_word[31:24], held);
    chk(spi_cs_n, "R7", "no background poll frame", spi_cs_n, 1);

    // next request absorbs the erase busy time (4 polls)
    post_busy = 0;
    run_op(2'd0, 24'hFF_FF_FF, 8'h00);
    // erase through the alternate code 3
    run_op(2'd3, 24'h7E_D0_00, 8'h00);

    // R3: very long busy period
    busy_left = 400; stat_hi = 7'h02;
    run_op(2'd1, 24'h00_00_01, 8'hC3);

    // random mix
    for (int k = 0; k < 40; k++) begin
      busy_left = $urandom % 6;
      post_busy = $urandom % 4;
      stat_hi   = 7'($urandom);
      run_op(2'($urandom), 24'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL R3 watchdog expired: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule